// File: doc/BRIEF.md
# Wide-to-Byte Boot Memory Bridge

The bridge connects a 32-bit processor local bus to two byte-wide nonvolatile memories: a 1M x 8 flash device and an EPROM. Every bus request, whether byte, word or longword, is carried out as a short run of single-byte device cycles. The bridge assembles the read bytes into the proper data lanes and hands the write bytes out one per device cycle. A burst request never reaches the memories as a burst. It is broken into four ordinary longword transfers, and each of these is acknowledged on its own.

Two 1 MB address windows are decoded. One of them covers the reset-vector region. A strap input is captured during reset and decides which device answers in that region, so boot code can run from either the EPROM or the flash. Each device cycle holds its strobes for a programmable number of clocks. Requests that are misaligned, or that fall outside both windows, are refused with a bus error and cause no device activity.

The master holds its request and address until the final acknowledge or the error. It lowers the request in the clock in which it sees that response.

Top module: `boot_byte_bridge`

## Requirements
- R1: A byte, word or longword request (`size_i` = 0, 1, 2) produces 1, 2 or 4 device cycles. The device addresses are consecutive, start at `addr_i[19:0]`, and are driven on all 20 bits of `mem_addr_o`.
- R2: Read data is big-endian. The byte read from device address `a` is placed on `rdata_o` bits `[8*(3-a[1:0]) +: 8]`. Lanes not covered by the request read as zero while `ack_o` is high.
- R3: On a write, the device cycle at address `a` drives `wdata_i` bits `[8*(3-a[1:0]) +: 8]` on `mem_wdata_o` and asserts `mem_we_o` instead of `mem_oe_o`.
- R4: A request with `burst_i` high is carried out as four longword transfers, at `addr_i`, +4, +8 and +12, in that order. Each transfer has four device cycles and its own acknowledge. The write data for longword k is sampled on the edge that ends the acknowledge of longword k-1.
- R5: Every device cycle holds chip-enable together with `mem_oe_o` or `mem_we_o` for exactly `wait_i` clocks, where a value of 0 counts as 1. The strobes are then low for at least one clock before the next device cycle.
- R6: `ack_o` is high for exactly one clock, in the clock after the last device cycle of each longword (or of the shorter request). Strobes are low in that clock and `rdata_o` is valid.
- R7: Window A is `addr_i[31:20]` = 0x000 and window B is 0xFF8. With the captured strap low, window A selects the EPROM (`eprom_ce_o`) and window B selects the flash (`flash_ce_o`). With the strap high, the two are swapped. The two chip-enables are never high together.
- R8: `boot_sel_i` is sampled only while `rst_ni` is low. A change after reset has no effect on the memory map.
- R9: A word request with `addr_i[0]` = 1, a longword or burst request with `addr_i[1:0]` not 0, or a non-burst request with `size_i` = 3 returns `err_o` for one clock and starts no device cycle.
- R10: A request whose `addr_i[31:20]` matches neither window returns a one-clock `err_o` and starts no device cycle.
- R11: During reset, all strobes, `ack_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| boot_sel_i | input | 1 | Boot-device strap, captured during reset |
| wait_i | input | 4 | Strobe length in clocks per device cycle (0 counts as 1) |
| req_i | input | 1 | Bus request, held until final acknowledge or error |
| we_i | input | 1 | Write when high |
| size_i | input | 2 | 0 byte, 1 word, 2 longword, 3 reserved |
| burst_i | input | 1 | Burst request, split into four longwords |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Write data, big-endian lanes |
| rdata_o | output | 32 | Read data, valid with ack_o |
| ack_o | output | 1 | One-clock transfer acknowledge per longword |
| err_o | output | 1 | One-clock bus error |
| mem_addr_o | output | 20 | Device byte address |
| mem_wdata_o | output | 8 | Device write byte |
| mem_rdata_i | input | 8 | Device read byte |
| flash_ce_o | output | 1 | Flash chip enable, active high |
| eprom_ce_o | output | 1 | EPROM chip enable, active high |
| mem_oe_o | output | 1 | Device output enable, active high |
| mem_we_o | output | 1 | Device write enable, active high |

## Verification
The bench targets several corner cases, each of which shows a specific wrong behaviour in a faulty design:
- Every byte position of word and longword reads: a lane-order mistake puts bytes in mirrored positions or leaves stale data in lanes the request does not cover.
- Bursts, both read and write: a design that counted beats wrongly gives the wrong number of acknowledges, repeats addresses, or writes the first longword's data four times.
- Wait counts of 0, 2 and 15: these expose an off-by-one in the strobe length.
- Misaligned and out-of-window requests: a faulty design would start stray device cycles instead of raising only a bus error.
- Toggling the strap after reset: a design that samples the strap continuously would move the boot window.
- Resetting with the strap high: a missing swap would select the wrong chip.

// File: rtl/bbb_pkg.sv
package bbb_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_GAP  = 2'd2,
    ST_ERR  = 2'd3
  } seq_state_e;

  localparam int unsigned BUS_BYTES   = 4;
  localparam int unsigned BURST_BEATS = 4;
  localparam int unsigned LANE_W      = $clog2(BUS_BYTES);
  localparam int unsigned BEAT_W      = $clog2(BURST_BEATS);
endpackage

// File: rtl/bbb_decode.sv
module bbb_decode
  import bbb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DEV_AW    = 20,
  parameter logic [31:0] WIN_A_TAG = 32'h000,
  parameter logic [31:0] WIN_B_TAG = 32'hFF8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boot_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              burst_i,
  output logic              sel_flash_o,
  output logic              bad_o
);
  localparam int unsigned WIN_W = ADDR_W - DEV_AW;

  logic             strap_q;
  logic             live_q;
  logic [WIN_W-1:0] tag;
  logic             hit_a, hit_b, long_acc, misal;
  xfer_size_e       sz;

  // strap follows the pin only while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) strap_q <= boot_sel_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  assign sz       = xfer_size_e'(size_i);
  assign tag      = addr_i[ADDR_W-1:DEV_AW];
  assign hit_a    = (tag == WIN_A_TAG[WIN_W-1:0]);
  assign hit_b    = (tag == WIN_B_TAG[WIN_W-1:0]);
  assign long_acc = burst_i || (sz == SZ_LONG);

  always_comb begin
    misal = 1'b0;
    if (long_acc)                 misal = |addr_i[1:0];
    else if (sz == SZ_WORD)       misal = addr_i[0];
    else if (sz == SZ_RSVD)       misal = 1'b1;
  end

  assign bad_o       = misal || !(hit_a || hit_b);
  assign sel_flash_o = hit_a ? strap_q : !strap_q;

  // R8
  strap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> $stable(strap_q));
endmodule

// File: rtl/bbb_seq.sv
module bbb_seq
  import bbb_pkg::*;
#(
  parameter int unsigned DEV_AW = 20,
  parameter int unsigned WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic              burst_i,
  input  logic [DEV_AW-1:0] addr_lo_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic              bad_i,
  input  logic              sel_flash_i,
  output logic              flash_ce_o,
  output logic              eprom_ce_o,
  output logic              mem_oe_o,
  output logic              mem_we_o,
  output logic [DEV_AW-1:0] dev_addr_o,
  output logic              ack_o,
  output logic              err_o,
  output logic              load_wd_o,
  output logic              clr_rd_o,
  output logic              cap_o
);
  seq_state_e        st_q, st_d;
  logic [DEV_AW-1:0] base_q;
  logic [LANE_W-1:0] last_b_q, bcnt_q;
  logic [BEAT_W-1:0] lcnt_q;
  logic [WAIT_W-1:0] lim_q, wcnt_q;
  logic              burst_q, we_q, flash_q;
  logic              accept, reject, act, act_end, last_byte, more_lw;
  logic [LANE_W-1:0] last_b_d;
  logic [WAIT_W-1:0] lim_d;
  xfer_size_e        sz;

  assign sz        = xfer_size_e'(size_i);
  assign accept    = (st_q == ST_IDLE) && req_i && !bad_i;
  assign reject    = (st_q == ST_IDLE) && req_i && bad_i;
  assign act       = (st_q == ST_ACT);
  assign act_end   = act && (wcnt_q == lim_q);
  assign last_byte = (st_q == ST_GAP) && (bcnt_q == last_b_q);
  assign more_lw   = burst_q && (lcnt_q != BEAT_W'(BURST_BEATS - 1));

  always_comb begin
    if (burst_i)               last_b_d = LANE_W'(BUS_BYTES - 1);
    else if (sz == SZ_WORD)    last_b_d = LANE_W'(1);
    else if (sz == SZ_LONG)    last_b_d = LANE_W'(BUS_BYTES - 1);
    else                       last_b_d = '0;
    lim_d = (wait_i == '0) ? WAIT_W'(1) : wait_i;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = ST_ACT;
               else if (reject) st_d = ST_ERR;
      ST_ACT:  if (act_end) st_d = ST_GAP;
      ST_GAP:  st_d = (last_byte && !more_lw) ? ST_IDLE : ST_ACT;
      ST_ERR:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      base_q   <= '0;
      last_b_q <= '0;
      bcnt_q   <= '0;
      lcnt_q   <= '0;
      lim_q    <= WAIT_W'(1);
      wcnt_q   <= WAIT_W'(1);
      burst_q  <= 1'b0;
      we_q     <= 1'b0;
      flash_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        base_q   <= addr_lo_i;
        last_b_q <= last_b_d;
        burst_q  <= burst_i;
        we_q     <= we_i;
        flash_q  <= sel_flash_i;
        lim_q    <= lim_d;
        bcnt_q   <= '0;
        lcnt_q   <= '0;
        wcnt_q   <= WAIT_W'(1);
      end else if (act && !act_end) begin
        wcnt_q <= wcnt_q + WAIT_W'(1);
      end else if (st_q == ST_GAP) begin
        wcnt_q <= WAIT_W'(1);
        if (last_byte) begin
          bcnt_q <= '0;
          if (more_lw) lcnt_q <= lcnt_q + BEAT_W'(1);
        end else begin
          bcnt_q <= bcnt_q + LANE_W'(1);
        end
      end
    end
  end

  assign dev_addr_o = base_q + {{(DEV_AW-LANE_W-BEAT_W){1'b0}}, lcnt_q, bcnt_q};
  assign flash_ce_o = act && flash_q;
  assign eprom_ce_o = act && !flash_q;
  assign mem_oe_o   = act && !we_q;
  assign mem_we_o   = act && we_q;
  assign ack_o      = last_byte;
  assign err_o      = (st_q == ST_ERR);
  assign load_wd_o  = accept || (last_byte && more_lw);
  assign clr_rd_o   = load_wd_o;
  assign cap_o      = act_end && !we_q;

  // strobe length monitor
  logic              act_q;
  logic [WAIT_W:0]   sw_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= 1'b0;
      sw_cnt_q <= '0;
    end else begin
      act_q    <= act;
      sw_cnt_q <= act ? sw_cnt_q + (WAIT_W+1)'(1) : '0;
    end
  end

  // R5
  strobe_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !act) |-> (sw_cnt_q == {1'b0, lim_q}));
  // R6
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  // R6
  ack_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !(flash_ce_o || eprom_ce_o));
  // R9
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
  // R9
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !(flash_ce_o || eprom_ce_o));
  // R7
  ce_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flash_ce_o && eprom_ce_o));
endmodule

// File: rtl/bbb_lanes.sv
module bbb_lanes
  import bbb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       wdata_i,
  input  logic [7:0]        mem_rdata_i,
  input  logic [LANE_W-1:0] dev_lo_i,
  input  logic              load_i,
  input  logic              clr_i,
  input  logic              cap_i,
  output logic [31:0]       rdata_o,
  output logic [7:0]        mem_wdata_o
);
  logic [BUS_BYTES-1:0][7:0] wd_q, rd_q;
  logic [LANE_W-1:0]         lane;

  // big-endian: lowest device address lands in the top lane
  assign lane = LANE_W'(BUS_BYTES - 1) - dev_lo_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wd_q <= '0;
    else if (load_i) wd_q <= wdata_i;
  end

  for (genvar g = 0; g < BUS_BYTES; g++) begin : g_rd_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              rd_q[g] <= '0;
      else if (clr_i)                           rd_q[g] <= '0;
      else if (cap_i && (lane == LANE_W'(g)))   rd_q[g] <= mem_rdata_i;
    end
  end

  assign rdata_o     = rd_q;
  assign mem_wdata_o = wd_q[lane];

  // R2
  clr_cap_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_i && cap_i));
endmodule

// File: rtl/boot_byte_bridge.sv
module boot_byte_bridge
  import bbb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DEV_AW    = 20,
  parameter int unsigned WAIT_W    = 4,
  parameter logic [31:0] WIN_A_TAG = 32'h000,
  parameter logic [31:0] WIN_B_TAG = 32'hFF8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boot_sel_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic              burst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              ack_o,
  output logic              err_o,
  output logic [DEV_AW-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              flash_ce_o,
  output logic              eprom_ce_o,
  output logic              mem_oe_o,
  output logic              mem_we_o
);
  logic              sel_flash, bad, load_wd, clr_rd, cap;
  logic [DEV_AW-1:0] dev_addr;

  bbb_decode #(
    .ADDR_W(ADDR_W), .DEV_AW(DEV_AW),
    .WIN_A_TAG(WIN_A_TAG), .WIN_B_TAG(WIN_B_TAG)
  ) u_decode (
    .clk_i, .rst_ni, .boot_sel_i, .addr_i, .size_i, .burst_i,
    .sel_flash_o(sel_flash), .bad_o(bad)
  );

  bbb_seq #(.DEV_AW(DEV_AW), .WAIT_W(WAIT_W)) u_seq (
    .clk_i, .rst_ni, .req_i, .we_i, .size_i, .burst_i,
    .addr_lo_i(addr_i[DEV_AW-1:0]), .wait_i,
    .bad_i(bad), .sel_flash_i(sel_flash),
    .flash_ce_o, .eprom_ce_o, .mem_oe_o, .mem_we_o,
    .dev_addr_o(dev_addr), .ack_o, .err_o,
    .load_wd_o(load_wd), .clr_rd_o(clr_rd), .cap_o(cap)
  );

  bbb_lanes u_lanes (
    .clk_i, .rst_ni, .wdata_i, .mem_rdata_i,
    .dev_lo_i(dev_addr[LANE_W-1:0]),
    .load_i(load_wd), .clr_i(clr_rd), .cap_i(cap),
    .rdata_o, .mem_wdata_o
  );

  assign mem_addr_o = dev_addr;

  // R11
  rst_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !(flash_ce_o || eprom_ce_o || mem_oe_o || mem_we_o || ack_o || err_o));
  // R3
  dir_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_oe_o && mem_we_o));
endmodule

// File: tb/boot_byte_bridge_test.sv
module boot_byte_bridge_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        boot_sel_i = 1'b0;
  logic [3:0]  wait_i = 4'd2;
  logic        req_i = 1'b0, we_i = 1'b0, burst_i = 1'b0;
  logic [1:0]  size_i = 2'd0;
  logic [31:0] addr_i = '0, wdata_i = '0;
  logic [31:0] rdata_o;
  logic        ack_o, err_o;
  logic [19:0] mem_addr_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i;
  logic        flash_ce_o, eprom_ce_o, mem_oe_o, mem_we_o;

  always #2 clk = ~clk;

  boot_byte_bridge uut (
    .clk_i(clk), .rst_ni, .boot_sel_i, .wait_i, .req_i, .we_i, .size_i,
    .burst_i, .addr_i, .wdata_i, .rdata_o, .ack_o, .err_o, .mem_addr_o,
    .mem_wdata_o, .mem_rdata_i, .flash_ce_o, .eprom_ce_o, .mem_oe_o, .mem_we_o
  );

  function automatic logic [7:0] model(input logic fl, input logic [19:0] a);
    return fl ? (a[7:0] ^ a[15:8] ^ 8'h3C) : (a[7:0] + 8'h71);
  endfunction

  assign mem_rdata_i = flash_ce_o ? model(1'b1, mem_addr_o) :
                       eprom_ce_o ? model(1'b0, mem_addr_o) : 8'h00;

  typedef struct packed { logic fl; logic wr; logic [19:0] a; logic [7:0] d; } dcyc_t;
  typedef struct packed { logic wr; logic [31:0] d; } ack_t;
  dcyc_t dq[$];
  ack_t  aq[$];

  int checks = 0, errors = 0;
  logic cur_strap = 1'b0;
  logic done = 1'b0;

  task automatic chk(input string tag, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // device-cycle monitor
  logic cs_q = 1'b0;
  int   w_cnt = 0;
  always @(negedge clk) begin
    logic cs;
    cs = flash_ce_o | eprom_ce_o;
    if (rst_ni && cs && !cs_q) begin
      if (dq.size() == 0) chk("R9 unexpected device cycle", 1'b0, {12'h0, mem_addr_o}, 32'h0);
      else begin
        dcyc_t e;
        e = dq.pop_front();
        chk("R7 device select", flash_ce_o == e.fl, {31'h0, flash_ce_o}, {31'h0, e.fl});
        chk("R1 device address", mem_addr_o == e.a, {12'h0, mem_addr_o}, {12'h0, e.a});
        chk("R3 direction", (mem_we_o == e.wr) && (mem_oe_o == !e.wr), {31'h0, mem_we_o}, {31'h0, e.wr});
        if (e.wr) chk("R3 write byte", mem_wdata_o == e.d, {24'h0, mem_wdata_o}, {24'h0, e.d});
      end
    end
    if (cs) w_cnt++;
    else if (cs_q) begin
      chk("R5 strobe length", w_cnt == ((wait_i == 0) ? 1 : int'(wait_i)), w_cnt, (wait_i == 0) ? 1 : wait_i);
      w_cnt = 0;
    end
    cs_q = cs;
  end

  // acknowledge monitor
  logic ack_q = 1'b0;
  always @(negedge clk) begin
    if (rst_ni && ack_o) begin
      chk("R6 ack single clock", !ack_q, {31'h0, ack_q}, 32'h0);
      if (aq.size() == 0) chk("R6 unexpected ack", 1'b0, 32'h1, 32'h0);
      else begin
        ack_t e;
        e = aq.pop_front();
        if (!e.wr) chk("R2 read lanes", rdata_o == e.d, rdata_o, e.d);
      end
    end
    ack_q = ack_o;
  end

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_ni = 1'b0;
    boot_sel_i = strap;
    repeat (3) @(negedge clk);
    chk("R11 reset quiet", !(flash_ce_o | eprom_ce_o | mem_oe_o | mem_we_o | ack_o | err_o),
        {26'h0, flash_ce_o, eprom_ce_o, mem_oe_o, mem_we_o, ack_o, err_o}, 32'h0);
    cur_strap = strap;
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic xfer(input string tag, input logic w, input logic [1:0] sz, input logic bst,
                      input logic [31:0] ad, input logic [31:0] d0, input logic [31:0] d1,
                      input logic [31:0] d2, input logic [31:0] d3);
    logic [31:0] wd[4];
    logic hit_a, hit_b, misal, bad, fl, got_err;
    int nl, nb, k, tmo;
    wd[0] = d0; wd[1] = d1; wd[2] = d2; wd[3] = d3;
    hit_a = (ad[31:20] == 12'h000);
    hit_b = (ad[31:20] == 12'hFF8);
    if (bst || sz == 2'd2) misal = |ad[1:0];
    else if (sz == 2'd1)   misal = ad[0];
    else                   misal = (sz == 2'd3);
    bad = misal || !(hit_a || hit_b);
    fl  = hit_a ? cur_strap : !cur_strap;
    nl  = bst ? 4 : 1;
    nb  = bst ? 4 : (sz == 2'd0 ? 1 : (sz == 2'd1 ? 2 : 4));
    if (!bad) begin
      for (int l = 0; l < nl; l++) begin
        logic [31:0] er;
        er = '0;
        for (int b = 0; b < nb; b++) begin
          logic [19:0] a;
          int lane;
          a = ad[19:0] + 20'(l * 4 + b);
          lane = 3 - int'(a[1:0]);
          if (w) dq.push_back('{fl, 1'b1, a, wd[l][8*lane +: 8]});
          else begin
            dq.push_back('{fl, 1'b0, a, 8'h00});
            er[8*lane +: 8] = model(fl, a);
          end
        end
        aq.push_back('{w, er});
      end
    end
    addr_i = ad; we_i = w; size_i = sz; burst_i = bst; wdata_i = wd[0];
    req_i = 1'b1;
    k = 0; got_err = 1'b0; tmo = 0;
    while (req_i) begin
      @(negedge clk);
      tmo++;
      if (ack_o) begin
        k++;
        if (k == nl) req_i = 1'b0;
        else wdata_i = wd[k];
      end
      if (err_o) begin
        got_err = 1'b1;
        req_i = 1'b0;
      end
      if (tmo > 2000) begin
        chk({tag, " transfer timeout"}, 1'b0, k, nl);
        req_i = 1'b0;
      end
    end
    chk({tag, " error response"}, got_err == bad, {31'h0, got_err}, {31'h0, bad});
    if (!bad) chk({tag, " R6 ack count"}, k == nl, k, nl);
    @(negedge clk);
    if (bad) chk({tag, " R9 error one clock"}, !err_o, {31'h0, err_o}, 32'h0);
    @(negedge clk);
    chk({tag, " R1 all device cycles seen"}, dq.size() == 0 && aq.size() == 0, dq.size() + aq.size(), 0);
    dq.delete(); aq.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);
    wait_i = 4'd2;
    // R1 R2: bytes in every lane from the flash window
    for (int i = 0; i < 4; i++) xfer("R1 byte read", 1'b0, 2'd0, 1'b0, 32'hFF80_0010 + i, 0, 0, 0, 0);
    xfer("R2 word read upper", 1'b0, 2'd1, 1'b0, 32'hFF80_0020, 0, 0, 0, 0);
    xfer("R2 word read lower", 1'b0, 2'd1, 1'b0, 32'hFF80_0022, 0, 0, 0, 0);
    xfer("R1 long read top", 1'b0, 2'd2, 1'b0, 32'hFF8F_FFFC, 0, 0, 0, 0);
    xfer("R7 long read eprom", 1'b0, 2'd2, 1'b0, 32'h0000_1234, 0, 0, 0, 0);
    // R3 writes
    xfer("R3 byte write", 1'b1, 2'd0, 1'b0, 32'hFF80_0041, 32'hA1B2_C3D4, 0, 0, 0);
    xfer("R3 word write", 1'b1, 2'd1, 1'b0, 32'hFF80_0042, 32'h1122_3344, 0, 0, 0);
    xfer("R3 long write", 1'b1, 2'd2, 1'b0, 32'h0000_0080, 32'hDEAD_BEEF, 0, 0, 0);
    // R5 wait extremes
    wait_i = 4'd0;
    xfer("R5 wait zero", 1'b0, 2'd2, 1'b0, 32'hFF80_0100, 0, 0, 0, 0);
    wait_i = 4'd15;
    xfer("R5 wait max", 1'b0, 2'd1, 1'b0, 32'h0000_0200, 0, 0, 0, 0);
    wait_i = 4'd1;
    // R4 bursts
    xfer("R4 burst read", 1'b0, 2'd2, 1'b1, 32'hFF80_0300, 0, 0, 0, 0);
    xfer("R4 burst write", 1'b1, 2'd0, 1'b1, 32'h0000_0044,
         32'h0102_0304, 32'h1112_1314, 32'h2122_2324, 32'h3132_3334);
    // R9 misaligned, R10 miss
    xfer("R9 word odd", 1'b0, 2'd1, 1'b0, 32'hFF80_0001, 0, 0, 0, 0);
    xfer("R9 long half", 1'b1, 2'd2, 1'b0, 32'hFF80_0002, 32'h5555_5555, 0, 0, 0);
    xfer("R9 burst misaligned", 1'b0, 2'd2, 1'b1, 32'h0000_0003, 0, 0, 0, 0);
    xfer("R9 reserved size", 1'b0, 2'd3, 1'b0, 32'h0000_0000, 0, 0, 0, 0);
    xfer("R10 window miss", 1'b0, 2'd0, 1'b0, 32'h1234_5678, 0, 0, 0, 0);
    // R8 strap change without reset keeps the map
    boot_sel_i = 1'b1;
    repeat (3) @(negedge clk);
    xfer("R8 strap ignored A", 1'b0, 2'd2, 1'b0, 32'h0000_0000, 0, 0, 0, 0);
    xfer("R8 strap ignored B", 1'b0, 2'd0, 1'b0, 32'hFF80_0005, 0, 0, 0, 0);
    // R7 swapped map
    do_reset(1'b1);
    wait_i = 4'd3;
    xfer("R7 swapped A flash", 1'b0, 2'd2, 1'b0, 32'h0000_0000, 0, 0, 0, 0);
    xfer("R7 swapped B eprom", 1'b0, 2'd1, 1'b0, 32'hFF80_0006, 0, 0, 0, 0);
    xfer("R4 burst swapped", 1'b0, 2'd2, 1'b1, 32'h0000_0010, 0, 0, 0, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule